// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-side directory for the memory blocks one node of a small distributed shared-memory machine owns. For every block it keeps a three-valued coherence state and a presence vector with one bit per remote node. Requests come in from remote nodes and from the home bus (read, read-for-ownership, writeback). The controller answers from home memory where it can. Otherwise it invalidates copies, forwards the request to the node that holds the block dirty, and collects the acknowledgements that close each transaction.

A block with an open transaction is marked busy. Any request that hits a busy block is refused with a negative acknowledgement and is not queued. There are three message streams: requests in, acknowledgements in, and messages out. Each uses valid/ready. An input item is consumed on a clock edge where both valid and ready are high. Acknowledgements always win over a request offered in the same cycle. While an outgoing message is offered, both inputs show ready low. An outgoing message holds all its fields until out_ready is high on a clock edge.

The controller handles one input item per decision and then emits its messages one at a time. The invalidates of a fan-out go out in ascending node order. Data is modelled only as a value/no-value flag.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty presence vector. out_valid is low, and req_ready and ack_ready are high.
- R2: A remote read (req_type 0) of an uncached or shared block is answered with a data message (out_type 0, out_data 1) to the requester. The block becomes shared and the requester's presence bit is set.
- R3: A remote read-for-ownership (req_type 1) of a shared block that other nodes hold sends an invalidate (out_type 3, out_rqstr = requester) to each other marked node, lowest index first. The ownership grant (out_type 1, out_data 1) goes out only after that many invalidate acknowledgements (ack_type 0). The requester is then the sole dirty holder.
- R4: A remote read of a dirty block owned by another node is forwarded (out_type 4) to the owner, with out_rqstr set to the requester. A writeback-done acknowledgement (ack_type 1) closes the transaction and leaves the block shared by the old owner and the requester.
- R5: A remote read-for-ownership of a block another node holds dirty is forwarded (out_type 5) to the owner. Only a transfer-done acknowledgement (ack_type 2) from the new owner completes it, and the block is then dirty at the new owner.
- R6: Home-bus requests (req_home 1) report completion with out_type 7 and out_home 1. A home read of a dirty block first forwards (out_type 4, out_home 1) and leaves the block shared by the old owner. A home read-for-ownership invalidates every marked node, waits for all their acknowledgements, and then leaves the block uncached.
- R7: Any request to a busy block is answered with a negative acknowledgement (out_type 2) to its source. The block's state is left unchanged.
- R8: A node whose presence bit is set still receives an invalidate even if it silently dropped its copy. The grant waits for that node's acknowledgement too.
- R9: A writeback (req_type 2) is always answered with out_type 6. From the dirty owner it makes the block uncached. From any other node it changes nothing.
- R10: An acknowledgement that matches no open transaction on its block (block not busy, wrong ack type, or a transfer-done from a node other than the new owner) is consumed with no message and no state change.
- R11: An outgoing message keeps all fields stable while out_valid is high and out_ready is low. When both inputs are offered in the same cycle, the acknowledgement is taken first.
- R12: A read-for-ownership of an uncached block, of a shared block held only by the requester, or of a block the requester already holds dirty, is granted at once (out_type 1).
- R13: At no time do two nodes hold dirty ownership of one block. A dirty block has exactly one presence bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this edge |
| req_type | input | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| req_addr | input | $clog2(BLOCKS) | Block index |
| req_src | input | $clog2(NODES) | Requesting node |
| req_home | input | 1 | Request comes from the home bus |
| ack_valid | input | 1 | Acknowledgement offered |
| ack_ready | output | 1 | Acknowledgement accepted this edge |
| ack_type | input | 2 | 0 invalidate done, 1 writeback done, 2 transfer done |
| ack_addr | input | $clog2(BLOCKS) | Block index |
| ack_src | input | $clog2(NODES) | Acknowledging node |
| out_valid | output | 1 | Message offered |
| out_ready | input | 1 | Network takes message |
| out_type | output | 3 | 0 data,1 grant,2 nack,3 invalidate,4 fwd read,5 fwd ownership,6 wb ack,7 home done |
| out_addr | output | $clog2(BLOCKS) | Block index |
| out_tgt | output | $clog2(NODES) | Destination node |
| out_rqstr | output | $clog2(NODES) | Node that opened the transaction |
| out_home | output | 1 | Transaction belongs to the home bus |
| out_data | output | 1 | Message carries the block value |

## Verification
Request sequences drive every block through all three states, from remote and home sources, so each transition is seen from each prior state. Overlapping traffic, where a new request arrives while invalidates or forwards are outstanding, separates the busy/refuse path from the normal paths. Stray, mistyped and early acknowledgements, silently dropped sharers and stale writebacks test whether completion is counted correctly. Requests and acknowledgements offered in the same cycle, together with a stalled out_ready, expose arbitration order and message hold.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_DIR = 2'd2} dstate_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_RFO = 2'd1, RQ_WB = 2'd2} rq_e;
  typedef enum logic [1:0] {AK_INV = 2'd0, AK_WB = 2'd1, AK_XFER = 2'd2} ak_e;
  typedef enum logic [2:0] {
    MS_DATA = 3'd0, MS_OWN = 3'd1, MS_NACK = 3'd2, MS_INVAL = 3'd3,
    MS_FWD_RD = 3'd4, MS_FWD_RFO = 3'd5, MS_WB_ACK = 3'd6, MS_HOME_DONE = 3'd7
  } msg_e;
  typedef enum logic [2:0] {
    PK_NONE = 3'd0, PK_RD_FWD = 3'd1, PK_RFO_INV = 3'd2, PK_RFO_FWD = 3'd3,
    PK_HOME_RD = 3'd4, PK_HOME_INV = 3'd5
  } pend_e;
  typedef enum logic [1:0] {EN_IDLE = 2'd0, EN_EMIT = 2'd1, EN_FAN = 2'd2} eng_e;
endpackage

// File: rtl/dir_lowest_set.sv
module dir_lowest_set #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  // the chosen index must point at a set bit (supports R3 ordering)
  always_comb begin
    if (any) begin
      assert_pick_in_mask_R3: assert (mask[idx]);
    end
  end
endmodule

// File: rtl/dir_entry_ram.sv
module dir_entry_ram import dir_pkg::*; #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int AW = $clog2(BLOCKS),
  localparam int NW = $clog2(NODES),
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output dstate_e          rd_state,
  output logic [NODES-1:0] rd_sharers,
  output logic             rd_busy,
  output logic [CW-1:0]    rd_pend,
  output pend_e            rd_kind,
  output logic [NW-1:0]    rd_rq,
  output logic             rd_home,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  dstate_e          wr_state,
  input  logic [NODES-1:0] wr_sharers,
  input  logic             wr_busy,
  input  logic [CW-1:0]    wr_pend,
  input  pend_e            wr_kind,
  input  logic [NW-1:0]    wr_rq,
  input  logic             wr_home
);
  dstate_e          st_q   [BLOCKS];
  logic [NODES-1:0] sh_q   [BLOCKS];
  logic             busy_q [BLOCKS];
  logic [CW-1:0]    pend_q [BLOCKS];
  pend_e            kind_q [BLOCKS];
  logic [NW-1:0]    rq_q   [BLOCKS];
  logic             home_q [BLOCKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]   <= ST_UNC;
        sh_q[b]   <= '0;
        busy_q[b] <= 1'b0;
        pend_q[b] <= '0;
        kind_q[b] <= PK_NONE;
        rq_q[b]   <= '0;
        home_q[b] <= 1'b0;
      end
    end else if (wr_en) begin
      st_q[wr_addr]   <= wr_state;
      sh_q[wr_addr]   <= wr_sharers;
      busy_q[wr_addr] <= wr_busy;
      pend_q[wr_addr] <= wr_pend;
      kind_q[wr_addr] <= wr_kind;
      rq_q[wr_addr]   <= wr_rq;
      home_q[wr_addr] <= wr_home;
    end
  end

  assign rd_state   = st_q[rd_addr];
  assign rd_sharers = sh_q[rd_addr];
  assign rd_busy    = busy_q[rd_addr];
  assign rd_pend    = pend_q[rd_addr];
  assign rd_kind    = kind_q[rd_addr];
  assign rd_rq      = rq_q[rd_addr];
  assign rd_home    = home_q[rd_addr];

  for (genvar b = 0; b < BLOCKS; b++) begin : g_chk
    assert_single_owner_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == ST_DIR) |-> ($countones(sh_q[b]) == 1));
    assert_busy_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[b] |-> (pend_q[b] != '0) && (kind_q[b] != PK_NONE));
    assert_uncached_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == ST_UNC) |-> (sh_q[b] == '0));
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl import dir_pkg::*; #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int AW = $clog2(BLOCKS),
  localparam int NW = $clog2(NODES),
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [NW-1:0] req_src,
  input  logic          req_home,
  input  logic          ack_valid,
  output logic          ack_ready,
  input  logic [1:0]    ack_type,
  input  logic [AW-1:0] ack_addr,
  input  logic [NW-1:0] ack_src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_type,
  output logic [AW-1:0] out_addr,
  output logic [NW-1:0] out_tgt,
  output logic [NW-1:0] out_rqstr,
  output logic          out_home,
  output logic          out_data
);
  function automatic logic [CW-1:0] pop_nodes(input logic [NODES-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  eng_e             eng_q;
  logic [2:0]       o_type_q;
  logic [AW-1:0]    o_addr_q;
  logic [NW-1:0]    o_tgt_q, o_rq_q;
  logic             o_home_q, o_data_q;
  logic [NODES-1:0] fan_mask_q;

  logic             take_ack, take_req;
  logic [AW-1:0]    sel_addr;
  dstate_e          rd_state, wr_state;
  logic [NODES-1:0] rd_sharers, wr_sharers;
  logic             rd_busy, wr_busy, rd_home, wr_home, wr_en;
  logic [CW-1:0]    rd_pend, wr_pend;
  pend_e            rd_kind, wr_kind;
  logic [NW-1:0]    rd_rq, wr_rq;

  logic [NW-1:0]    owner_idx, fan_idx;
  logic             owner_any, fan_any;
  logic [NODES-1:0] src_bit, rq_bit, others, fan_left;

  logic             go_emit, go_fan;
  msg_e             n_type;
  logic [NW-1:0]    n_tgt, n_rq;
  logic             n_home;
  logic [NODES-1:0] n_mask;

  // acknowledgements drain first so pending transactions can always close
  assign ack_ready = (eng_q == EN_IDLE);
  assign req_ready = (eng_q == EN_IDLE) && !ack_valid;
  assign take_ack  = ack_ready && ack_valid;
  assign take_req  = req_ready && req_valid;
  assign sel_addr  = ack_valid ? ack_addr : req_addr;

  dir_entry_ram #(.NODES(NODES), .BLOCKS(BLOCKS)) u_ram (
    .clk(clk), .rst_n(rst_n), .rd_addr(sel_addr),
    .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_busy(rd_busy),
    .rd_pend(rd_pend), .rd_kind(rd_kind), .rd_rq(rd_rq), .rd_home(rd_home),
    .wr_en(wr_en), .wr_addr(sel_addr), .wr_state(wr_state),
    .wr_sharers(wr_sharers), .wr_busy(wr_busy), .wr_pend(wr_pend),
    .wr_kind(wr_kind), .wr_rq(wr_rq), .wr_home(wr_home)
  );

  dir_lowest_set #(.W(NODES)) u_owner_pick (
    .mask(rd_sharers), .idx(owner_idx), .any(owner_any)
  );
  dir_lowest_set #(.W(NODES)) u_fan_pick (
    .mask(fan_mask_q), .idx(fan_idx), .any(fan_any)
  );

  assign src_bit  = NODES'(1) << req_src;
  assign rq_bit   = NODES'(1) << rd_rq;
  assign others   = rd_sharers & ~src_bit;
  assign fan_left = fan_mask_q & ~(NODES'(1) << fan_idx);

  always_comb begin
    wr_en      = 1'b0;
    wr_state   = rd_state;
    wr_sharers = rd_sharers;
    wr_busy    = rd_busy;
    wr_pend    = rd_pend;
    wr_kind    = rd_kind;
    wr_rq      = rd_rq;
    wr_home    = rd_home;
    go_emit    = 1'b0;
    go_fan     = 1'b0;
    n_type     = MS_NACK;
    n_tgt      = req_src;
    n_rq       = req_src;
    n_home     = req_home;
    n_mask     = '0;
    if (take_ack) begin
      n_tgt  = rd_rq;
      n_rq   = rd_rq;
      n_home = rd_home;
      if (rd_busy) begin
        case (ack_type)
          AK_INV: begin
            if (rd_kind == PK_RFO_INV || rd_kind == PK_HOME_INV) begin
              wr_en   = 1'b1;
              wr_pend = rd_pend - CW'(1);
              if (rd_pend == CW'(1)) begin
                wr_busy = 1'b0;
                wr_kind = PK_NONE;
                go_emit = 1'b1;
                if (rd_kind == PK_RFO_INV) begin
                  wr_state   = ST_DIR;
                  wr_sharers = rq_bit;
                  n_type     = MS_OWN;
                end else begin
                  wr_state   = ST_UNC;
                  wr_sharers = '0;
                  n_type     = MS_HOME_DONE;
                end
              end
            end
          end
          AK_WB: begin
            if (rd_kind == PK_RD_FWD || rd_kind == PK_HOME_RD) begin
              wr_en    = 1'b1;
              wr_busy  = 1'b0;
              wr_pend  = '0;
              wr_kind  = PK_NONE;
              wr_state = ST_SHR;
              if (rd_kind == PK_RD_FWD) begin
                wr_sharers = rd_sharers | rq_bit;
              end else begin
                go_emit = 1'b1;
                n_type  = MS_HOME_DONE;
              end
            end
          end
          AK_XFER: begin
            if (rd_kind == PK_RFO_FWD && ack_src == rd_rq) begin
              wr_en      = 1'b1;
              wr_busy    = 1'b0;
              wr_pend    = '0;
              wr_kind    = PK_NONE;
              wr_state   = ST_DIR;
              wr_sharers = rq_bit;
            end
          end
          default: ;
        endcase
      end
    end else if (take_req) begin
      if (rd_busy) begin
        go_emit = 1'b1;
        n_type  = MS_NACK;
      end else if (req_home) begin
        case (req_type)
          RQ_READ: begin
            go_emit = 1'b1;
            if (rd_state == ST_DIR) begin
              n_type  = MS_FWD_RD;
              n_tgt   = owner_idx;
              wr_en   = 1'b1;
              wr_busy = 1'b1;
              wr_pend = CW'(1);
              wr_kind = PK_HOME_RD;
              wr_rq   = req_src;
              wr_home = 1'b1;
            end else begin
              n_type = MS_HOME_DONE;
            end
          end
          RQ_RFO: begin
            if (owner_any) begin
              go_fan  = 1'b1;
              n_mask  = rd_sharers;
              wr_en   = 1'b1;
              wr_busy = 1'b1;
              wr_pend = pop_nodes(rd_sharers);
              wr_kind = PK_HOME_INV;
              wr_rq   = req_src;
              wr_home = 1'b1;
            end else begin
              go_emit = 1'b1;
              n_type  = MS_HOME_DONE;
            end
          end
          default: begin
            go_emit = 1'b1;
            n_type  = MS_HOME_DONE;
          end
        endcase
      end else begin
        case (req_type)
          RQ_READ: begin
            go_emit = 1'b1;
            if (rd_state == ST_DIR && owner_idx != req_src) begin
              n_type  = MS_FWD_RD;
              n_tgt   = owner_idx;
              wr_en   = 1'b1;
              wr_busy = 1'b1;
              wr_pend = CW'(1);
              wr_kind = PK_RD_FWD;
              wr_rq   = req_src;
              wr_home = 1'b0;
            end else begin
              n_type = MS_DATA;
              if (rd_state != ST_DIR) begin
                wr_en      = 1'b1;
                wr_state   = ST_SHR;
                wr_sharers = rd_sharers | src_bit;
              end
            end
          end
          RQ_RFO: begin
            if (rd_state == ST_DIR && owner_idx != req_src) begin
              go_emit = 1'b1;
              n_type  = MS_FWD_RFO;
              n_tgt   = owner_idx;
              wr_en   = 1'b1;
              wr_busy = 1'b1;
              wr_pend = CW'(1);
              wr_kind = PK_RFO_FWD;
              wr_rq   = req_src;
              wr_home = 1'b0;
            end else if (others != '0) begin
              go_fan  = 1'b1;
              n_mask  = others;
              wr_en   = 1'b1;
              wr_busy = 1'b1;
              wr_pend = pop_nodes(others);
              wr_kind = PK_RFO_INV;
              wr_rq   = req_src;
              wr_home = 1'b0;
            end else begin
              go_emit    = 1'b1;
              n_type     = MS_OWN;
              wr_en      = 1'b1;
              wr_state   = ST_DIR;
              wr_sharers = src_bit;
            end
          end
          RQ_WB: begin
            go_emit = 1'b1;
            n_type  = MS_WB_ACK;
            if (rd_state == ST_DIR && owner_idx == req_src) begin
              wr_en      = 1'b1;
              wr_state   = ST_UNC;
              wr_sharers = '0;
            end
          end
          default: begin
            go_emit = 1'b1;
            n_type  = MS_NACK;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_q      <= EN_IDLE;
      o_type_q   <= '0;
      o_addr_q   <= '0;
      o_tgt_q    <= '0;
      o_rq_q     <= '0;
      o_home_q   <= 1'b0;
      o_data_q   <= 1'b0;
      fan_mask_q <= '0;
    end else begin
      case (eng_q)
        EN_IDLE: begin
          if (go_emit) begin
            eng_q    <= EN_EMIT;
            o_type_q <= n_type;
            o_addr_q <= sel_addr;
            o_tgt_q  <= n_tgt;
            o_rq_q   <= n_rq;
            o_home_q <= n_home;
            o_data_q <= (n_type == MS_DATA) || (n_type == MS_OWN);
          end else if (go_fan) begin
            eng_q      <= EN_FAN;
            o_type_q   <= MS_INVAL;
            o_addr_q   <= sel_addr;
            o_rq_q     <= n_rq;
            o_home_q   <= n_home;
            o_data_q   <= 1'b0;
            fan_mask_q <= n_mask;
          end
        end
        EN_EMIT: begin
          if (out_ready) eng_q <= EN_IDLE;
        end
        EN_FAN: begin
          if (out_ready) begin
            fan_mask_q <= fan_left;
            if (fan_left == '0) eng_q <= EN_IDLE;
          end
        end
        default: eng_q <= EN_IDLE;
      endcase
    end
  end

  assign out_valid = (eng_q != EN_IDLE);
  assign out_type  = o_type_q;
  assign out_addr  = o_addr_q;
  assign out_tgt   = (eng_q == EN_FAN) ? fan_idx : o_tgt_q;
  assign out_rqstr = o_rq_q;
  assign out_home  = o_home_q;
  assign out_data  = o_data_q;

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_addr)
      && $stable(out_tgt) && $stable(out_rqstr) && $stable(out_home)));
  assert_fan_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_q == EN_FAN) |-> fan_any);
  assert_nack_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && rd_busy) |-> !wr_en);
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int BLOCKS = 8;
  localparam int WATCHDOG = 50000;

  typedef struct packed {
    logic [2:0] typ;
    logic [2:0] addr;
    logic [1:0] tgt;
    logic [1:0] rq;
    logic       home;
    logic       data;
  } msg_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_home = 0, ack_valid = 0, out_ready = 1;
  logic [1:0] req_type = 0, ack_type = 0, req_src = 0, ack_src = 0;
  logic [2:0] req_addr = 0, ack_addr = 0;
  logic req_ready, ack_ready, out_valid, out_home, out_data;
  logic [2:0] out_type, out_addr;
  logic [1:0] out_tgt, out_rqstr;

  int n_chk = 0, n_fail = 0;
  msg_t  exp_q[$];
  string tag_q[$];
  int own_tb[BLOCKS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_src(req_src), .req_home(req_home),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_type(ack_type),
    .ack_addr(ack_addr), .ack_src(ack_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_addr(out_addr), .out_tgt(out_tgt), .out_rqstr(out_rqstr),
    .out_home(out_home), .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_msg(string tag, int typ, int addr, int tgt, int rq, bit home);
    msg_t m;
    m.typ = 3'(typ); m.addr = 3'(addr); m.tgt = 2'(tgt); m.rq = 2'(rq);
    m.home = home; m.data = (typ == 0) || (typ == 1);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic send_req(int ty, int ad, int src, bit home);
    bit done;
    done = 0;
    @(negedge clk);
    req_type = 2'(ty); req_addr = 3'(ad); req_src = 2'(src); req_home = home;
    req_valid = 1;
    while (!done) begin
      #1;
      done = req_ready;
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic send_ack(int ty, int ad, int src);
    bit done;
    done = 0;
    @(negedge clk);
    ack_type = 2'(ty); ack_addr = 3'(ad); ack_src = 2'(src);
    ack_valid = 1;
    while (!done) begin
      #1;
      done = ack_ready;
      @(negedge clk);
    end
    ack_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected messages, tracks dirty holders (R13)
  always @(negedge clk) begin
    msg_t got, e;
    string t;
    #2;
    if (rst_n && out_valid && out_ready) begin
      got = '{typ: out_type, addr: out_addr, tgt: out_tgt, rq: out_rqstr,
              home: out_home, data: out_data};
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected message actual=%h expected=none", got);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, int'(got), int'(e));
      end
      case (got.typ)
        3'd1: begin
          chk(own_tb[got.addr] == -1 || own_tb[got.addr] == int'(got.tgt),
              "R13 second dirty holder", own_tb[got.addr], int'(got.tgt));
          own_tb[got.addr] = int'(got.tgt);
        end
        3'd3, 3'd4, 3'd6: if (own_tb[got.addr] == int'(got.tgt)) own_tb[got.addr] = -1;
        3'd5: own_tb[got.addr] = int'(got.rq);
        default: ;
      endcase
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] h_type;
    logic [1:0] h_tgt;
    for (int b = 0; b < BLOCKS; b++) own_tb[b] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(req_ready == 1 && ack_ready == 1, "R1 ready after reset", req_ready, 1);

    // R2 reads of uncached then shared block
    expect_msg("R2 data to 1", 0, 0, 1, 1, 0); send_req(0, 0, 1, 0);
    expect_msg("R2 data to 2", 0, 0, 2, 2, 0); send_req(0, 0, 2, 0);
    drain();

    // R3 ownership with invalidates, R7 nack while pending
    expect_msg("R3 inval 1", 3, 0, 1, 3, 0);
    expect_msg("R3 inval 2", 3, 0, 2, 3, 0);
    send_req(1, 0, 3, 0); drain();
    expect_msg("R7 nack busy", 2, 0, 0, 0, 0); send_req(0, 0, 0, 0); drain();
    send_ack(0, 0, 1); drain();
    expect_msg("R3 grant after acks", 1, 0, 3, 3, 0); send_ack(0, 0, 2); drain();

    // R4 read of dirty is forwarded, then shared by both
    expect_msg("R4 fwd read", 4, 0, 3, 0, 0); send_req(0, 0, 0, 0); drain();
    send_ack(1, 0, 3); drain();
    expect_msg("R4 inval 0", 3, 0, 0, 1, 0);
    expect_msg("R4 inval 3", 3, 0, 3, 1, 0);
    send_req(1, 0, 1, 0); drain();
    send_ack(0, 0, 0);
    expect_msg("R4 grant", 1, 0, 1, 1, 0); send_ack(0, 0, 3); drain();

    // R5 ownership transfer
    expect_msg("R5 fwd rfo", 5, 0, 1, 2, 0); send_req(1, 0, 2, 0); drain();
    expect_msg("R7 nack during transfer", 2, 0, 3, 3, 0); send_req(0, 0, 3, 0); drain();
    send_ack(2, 0, 2); drain();
    expect_msg("R5 new owner 2", 4, 0, 2, 0, 0); send_req(0, 0, 0, 0); drain();
    send_ack(1, 0, 2); drain();

    // R6 home-bus requests
    expect_msg("R6 home inval 0", 3, 0, 0, 0, 1);
    expect_msg("R6 home inval 2", 3, 0, 2, 0, 1);
    send_req(1, 0, 0, 1); drain();
    send_ack(0, 0, 0);
    expect_msg("R6 home done", 7, 0, 0, 0, 1); send_ack(0, 0, 2); drain();
    expect_msg("R12 grant uncached", 1, 0, 1, 1, 0); send_req(1, 0, 1, 0); drain();
    expect_msg("R6 home fwd read", 4, 0, 1, 0, 1); send_req(0, 0, 0, 1); drain();
    expect_msg("R6 home read done", 7, 0, 0, 0, 1); send_ack(1, 0, 1); drain();
    expect_msg("R6 old owner shared", 3, 0, 1, 3, 0); send_req(1, 0, 3, 0); drain();
    expect_msg("R6 grant 3", 1, 0, 3, 3, 0); send_ack(0, 0, 1); drain();
    expect_msg("R6 grant blk1", 1, 1, 2, 2, 0); send_req(1, 1, 2, 0); drain();
    expect_msg("R6 home inval owner", 3, 1, 2, 0, 1); send_req(1, 1, 0, 1); drain();
    expect_msg("R6 home done blk1", 7, 1, 0, 0, 1); send_ack(0, 1, 2); drain();
    expect_msg("R6 uncached read", 0, 1, 3, 3, 0); send_req(0, 1, 3, 0); drain();

    // R8 dropped sharer still must ack
    expect_msg("R8 data 0", 0, 2, 0, 0, 0); send_req(0, 2, 0, 0);
    expect_msg("R8 data 1", 0, 2, 1, 1, 0); send_req(0, 2, 1, 0); drain();
    expect_msg("R8 inval 0", 3, 2, 0, 2, 0);
    expect_msg("R8 inval 1", 3, 2, 1, 2, 0);
    send_req(1, 2, 2, 0); drain();
    send_ack(0, 2, 1); drain();
    #1; chk(out_valid == 0, "R8 no grant before all acks", out_valid, 0);
    expect_msg("R8 grant", 1, 2, 2, 2, 0); send_ack(0, 2, 0); drain();

    // R9 writebacks
    expect_msg("R9 stale wb ack", 6, 2, 1, 1, 0); send_req(2, 2, 1, 0); drain();
    expect_msg("R9 owner unchanged", 4, 2, 2, 3, 0); send_req(0, 2, 3, 0); drain();
    send_ack(1, 2, 2); drain();
    expect_msg("R9 grant blk3", 1, 3, 3, 3, 0); send_req(1, 3, 3, 0); drain();
    expect_msg("R9 owner wb ack", 6, 3, 3, 3, 0); send_req(2, 3, 3, 0); drain();
    expect_msg("R9 uncached after wb", 0, 3, 0, 0, 0); send_req(0, 3, 0, 0); drain();
    expect_msg("R12 sole sharer grant", 1, 3, 0, 0, 0); send_req(1, 3, 0, 0); drain();
    expect_msg("R12 owner regrant", 1, 3, 0, 0, 0); send_req(1, 3, 0, 0); drain();

    // R10 stray and mismatched acks
    send_ack(0, 5, 1); send_ack(2, 4, 2); drain();
    #1; chk(out_valid == 0, "R10 stray ack silent", out_valid, 0);
    expect_msg("R10 block5 untouched", 0, 5, 1, 1, 0); send_req(0, 5, 1, 0); drain();
    expect_msg("R10 grant blk6", 1, 6, 0, 0, 0); send_req(1, 6, 0, 0); drain();
    expect_msg("R10 fwd rfo blk6", 5, 6, 0, 1, 0); send_req(1, 6, 1, 0); drain();
    send_ack(0, 6, 1); send_ack(2, 6, 3); drain();
    expect_msg("R10 still busy", 2, 6, 2, 2, 0); send_req(0, 6, 2, 0); drain();
    send_ack(2, 6, 1); drain();
    expect_msg("R10 transfer done", 4, 6, 1, 3, 0); send_req(0, 6, 3, 0); drain();
    send_ack(1, 6, 1); drain();

    // R11 ack priority over simultaneous request
    expect_msg("R11 grant blk4", 1, 4, 1, 1, 0); send_req(1, 4, 1, 0); drain();
    expect_msg("R11 fwd rfo blk4", 5, 4, 1, 2, 0); send_req(1, 4, 2, 0); drain();
    expect_msg("R11 ack taken first", 4, 4, 2, 3, 0);
    fork
      send_ack(2, 4, 2);
      send_req(0, 4, 3, 0);
    join
    drain();
    send_ack(1, 4, 2); drain();

    // R11 back-pressure hold
    @(negedge clk); out_ready = 0;
    send_req(0, 7, 2, 0);
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 1, "R11 held valid", out_valid, 1);
    chk(req_ready == 0, "R11 no accept while emitting", req_ready, 0);
    h_type = out_type; h_tgt = out_tgt;
    repeat (3) @(negedge clk);
    #1;
    chk(out_type == h_type && out_tgt == h_tgt && out_valid == 1,
        "R11 fields stable", int'(out_type), int'(h_type));
    expect_msg("R11 data after stall", 0, 7, 2, 2, 0);
    @(negedge clk); out_ready = 1;
    drain();

    chk(exp_q.size() == 0, "R2 all expected seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule